// File: doc/BRIEF.md
# Hardware Buddy Block Allocator

This block hands out and takes back power-of-two blocks of a managed address region. A client asks for a block of a given size class and gets back the byte address of a free block, or a failure flag when nothing large enough remains. Later the client returns the block by giving the same address and class. The block needs no other information to take it back.

Internally every size class has two small bitmaps. One marks which blocks of that size are free, and a priority encoder picks the lowest-numbered free block. The other holds one bit per buddy pair. That bit is the XOR of the two buddies' allocation states, so on its own it decides whether a returned block can merge with its partner. An allocation takes the smallest class at or above the request that has a free block. It splits that block downward one class per cycle, and each split puts the upper half back as free. A release climbs the classes one per cycle and merges with the buddy for as long as the pair bit says the buddy is free.

The client uses a single request/acknowledge handshake. While an operation is in progress the block holds `busy` high and takes no new requests.

Top module: `buddy_alloc`

## Requirements
- R1: After reset `busy` and `ack` are low, and the whole region is free. It is held as TOP_CNT blocks of the largest class.
- R2: A request is accepted on a rising edge where `req_valid` is high and `busy` is low, with `req_op` 0 meaning allocate and 1 meaning release. A block of class c spans 2^(MIN_ORDER+c) bytes. Its address is its index within that class shifted left by MIN_ORDER+c.
- R3: An allocate of class d is served from the smallest class x >= d that holds a free block, taking the lowest-indexed one there. When x > d the block is split down to class d: the lower half is kept each time and the upper half is marked free. The response carries `ack_ok` = 1 and the address of the kept class-d block.
- R4: When no class from d to the top holds a free block, the response has `ack_ok` = 0 and `ack_addr` = 0. The free state is left unchanged.
- R5: A release of class d merges with its buddy while the buddy is wholly free, and then continues at the next class up. It stops at the first class whose buddy is in use, or at the top class, where there is no merge. The response has `ack_ok` = 1 and `ack_addr` equal to the address of the resulting merged free block.
- R6: Count rising edges after the accepting edge. An allocate that splits from class x to d raises `ack` after x-d edges. A failed allocate raises it after 0 edges. A release whose merged block ends at class m raises it after m-d+1 edges.
- R7: `busy` is high from the accepting edge until the acknowledge. A request presented while `busy` is high is ignored and leaves the free state unchanged.
- R8: `ack` is a one-cycle pulse for each accepted request, and `busy` is low while `ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_class | input | LW | Size class c, block of 2^(MIN_ORDER+c) bytes |
| req_addr | input | AW | Block address for a release |
| busy | output | 1 | Operation in progress, requests ignored |
| ack | output | 1 | One-cycle response strobe |
| ack_ok | output | 1 | 1 = success, 0 = allocate failed |
| ack_addr | output | AW | Allocated block, or merged block after a release |

## Verification
The bench keeps a granule-level occupancy model. It derives the expected free blocks as maximal aligned free regions, so errors in splitting, merging or pair-bit upkeep show up as a wrong returned address.

Filling the region at every class checks that the upper halves are pushed back free. A design that dropped them would fail early, with space still left. Releasing the blocks in forward, reverse and scattered orders checks the full merge chain to the top. A wrongly kept pair bit would leave fragments, and a later top-class allocate would then fail. A request poked in while the block is busy must not be accepted. If it were, the next address would be off.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } buddy_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPLIT = 2'd1,
    ST_MERGE = 2'd2
  } buddy_state_e;
endpackage

// File: rtl/buddy_lowbit.sv
// Lowest set bit finder over one class free bitmap.
module buddy_lowbit #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/buddy_class_search.sv
// First class at or above the start class that holds a free block.
module buddy_class_search #(
  parameter int LEVELS = 4,
  parameter int LW     = 2
) (
  input  logic [LEVELS-1:0] nonempty,
  input  logic [LW-1:0]     start,
  output logic              found,
  output logic [LW-1:0]     lvl
);
  always_comb begin
    found = 1'b0;
    lvl   = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (nonempty[l] && (l >= int'(start))) begin
        found = 1'b1;
        lvl   = LW'(l);
      end
    end
  end
endmodule

// File: rtl/buddy_alloc.sv
// Buddy block allocator. TOP_CNT must be a power of two >= 2.
module buddy_alloc #(
  parameter int MIN_ORDER = 4,
  parameter int LEVELS    = 4,
  parameter int TOP_CNT   = 2,
  localparam int L0_CNT   = TOP_CNT << (LEVELS - 1),
  localparam int IW       = $clog2(L0_CNT),
  localparam int LW       = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int AW       = MIN_ORDER + IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_op,
  input  logic [LW-1:0] req_class,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          ack,
  output logic          ack_ok,
  output logic [AW-1:0] ack_addr
);
  import buddy_pkg::*;

  localparam int PW = L0_CNT / 2;
  localparam logic [LW-1:0] TOP_LVL = LW'(LEVELS - 1);

  logic [L0_CNT-1:0] free_map [LEVELS];
  logic [PW-1:0]     pair_map [LEVELS];

  buddy_state_e  state;
  logic [LW-1:0] cur_lvl, tgt_lvl;
  logic [IW-1:0] cur_idx;
  logic          ack_q, ok_q;
  logic [AW-1:0] addr_q;

  logic [LEVELS-1:0] nonempty;
  logic [IW-1:0]     low_idx [LEVELS];
  logic              s_found;
  logic [LW-1:0]     s_lvl;
  logic [IW-1:0]     s_idx;
  logic [IW-1:0]     rel_idx;
  logic [LW-1:0]     dn_lvl;
  logic [IW-1:0]     dn_idx;
  logic              pair_old;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    buddy_lowbit #(.W(L0_CNT), .IW(IW)) u_pick (
      .vec (free_map[l]),
      .any (nonempty[l]),
      .idx (low_idx[l])
    );
  end

  buddy_class_search #(.LEVELS(LEVELS), .LW(LW)) u_search (
    .nonempty (nonempty),
    .start    (req_class),
    .found    (s_found),
    .lvl      (s_lvl)
  );

  function automatic logic [AW-1:0] blk_addr(input logic [IW-1:0] idx,
                                             input logic [LW-1:0] lvl);
    return AW'(idx) << (MIN_ORDER + int'(lvl));
  endfunction

  always_comb begin
    s_idx    = low_idx[s_lvl];
    rel_idx  = IW'((req_addr >> MIN_ORDER) >> req_class);
    dn_lvl   = cur_lvl - LW'(1);
    dn_idx   = cur_idx << 1;
    pair_old = pair_map[cur_lvl][cur_idx[IW-1:1]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cur_lvl <= '0;
      tgt_lvl <= '0;
      cur_idx <= '0;
      ack_q   <= 1'b0;
      ok_q    <= 1'b0;
      addr_q  <= '0;
      for (int l = 0; l < LEVELS; l++) begin
        free_map[l] <= '0;
        pair_map[l] <= '0;
      end
      for (int i = 0; i < TOP_CNT; i++) free_map[LEVELS-1][i] <= 1'b1;
    end else begin
      ack_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_op == OP_ALLOC) begin
              if (!s_found) begin
                ack_q  <= 1'b1;
                ok_q   <= 1'b0;
                addr_q <= '0;
              end else begin
                free_map[s_lvl][s_idx] <= 1'b0;
                if (s_lvl != TOP_LVL)
                  pair_map[s_lvl][s_idx[IW-1:1]] <= ~pair_map[s_lvl][s_idx[IW-1:1]];
                cur_lvl <= s_lvl;
                cur_idx <= s_idx;
                tgt_lvl <= req_class;
                if (s_lvl == req_class) begin
                  ack_q  <= 1'b1;
                  ok_q   <= 1'b1;
                  addr_q <= blk_addr(s_idx, s_lvl);
                end else begin
                  state <= ST_SPLIT;
                end
              end
            end else begin
              cur_lvl <= req_class;
              cur_idx <= rel_idx;
              state   <= ST_MERGE;
            end
          end
        end
        ST_SPLIT: begin
          pair_map[dn_lvl][cur_idx[IW-2:0]] <= ~pair_map[dn_lvl][cur_idx[IW-2:0]];
          free_map[dn_lvl][dn_idx | IW'(1)] <= 1'b1;
          cur_lvl <= dn_lvl;
          cur_idx <= dn_idx;
          if (dn_lvl == tgt_lvl) begin
            ack_q  <= 1'b1;
            ok_q   <= 1'b1;
            addr_q <= blk_addr(dn_idx, dn_lvl);
            state  <= ST_IDLE;
          end
        end
        ST_MERGE: begin
          if (cur_lvl == TOP_LVL || !pair_old) begin
            if (cur_lvl != TOP_LVL)
              pair_map[cur_lvl][cur_idx[IW-1:1]] <= 1'b1;
            free_map[cur_lvl][cur_idx] <= 1'b1;
            ack_q  <= 1'b1;
            ok_q   <= 1'b1;
            addr_q <= blk_addr(cur_idx, cur_lvl);
            state  <= ST_IDLE;
          end else begin
            pair_map[cur_lvl][cur_idx[IW-1:1]] <= 1'b0;
            free_map[cur_lvl][cur_idx ^ IW'(1)] <= 1'b0;
            cur_idx <= cur_idx >> 1;
            cur_lvl <= cur_lvl + LW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign ack      = ack_q;
  assign ack_ok   = ok_q;
  assign ack_addr = addr_q;
endmodule

// File: rtl/buddy_alloc_chk.sv
module buddy_alloc_chk #(
  parameter int MIN_ORDER = 4,
  parameter int LEVELS    = 4,
  parameter int TOP_CNT   = 2,
  localparam int L0_CNT   = TOP_CNT << (LEVELS - 1),
  localparam int IW       = $clog2(L0_CNT),
  localparam int LW       = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int AW       = MIN_ORDER + IW
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [LW-1:0] req_class,
  input logic          busy,
  input logic          ack,
  input logic          ack_ok,
  input logic [AW-1:0] ack_addr
);
  logic [LW-1:0] cls_q;
  logic [AW-1:0] low_mask;

  always_ff @(posedge clk) begin
    if (rst) cls_q <= '0;
    else if (req_valid && !busy) cls_q <= req_class;
  end

  always_comb low_mask = ~({AW{1'b1}} << (MIN_ORDER + int'(cls_q)));

  // R1
  assert_reset_idle_R1: assert property (@(posedge clk) $past(rst) |-> (!busy && !ack));
  // R8
  assert_ack_not_busy_R8: assert property (@(posedge clk) disable iff (rst) ack |-> !busy);
  // R4
  assert_fail_addr_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (ack && !ack_ok) |-> (ack_addr == '0));
  // R2
  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    (ack && ack_ok) |-> ((ack_addr & low_mask) == '0));
  // R7
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack) |=> (busy || ack));
endmodule

bind buddy_alloc buddy_alloc_chk #(
  .MIN_ORDER (MIN_ORDER),
  .LEVELS    (LEVELS),
  .TOP_CNT   (TOP_CNT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_class (req_class),
  .busy      (busy),
  .ack       (ack),
  .ack_ok    (ack_ok),
  .ack_addr  (ack_addr)
);

// File: tb/tb_buddy_alloc.sv
`timescale 1ns/1ps
module tb_buddy_alloc;
  localparam int MIN_ORDER = 4;
  localparam int LEVELS    = 4;
  localparam int TOP_CNT   = 2;
  localparam int NG        = TOP_CNT << (LEVELS - 1);
  localparam int IW        = $clog2(NG);
  localparam int LW        = $clog2(LEVELS);
  localparam int AW        = MIN_ORDER + IW;
  localparam int TOP       = LEVELS - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_op;
  logic [LW-1:0] req_class;
  logic [AW-1:0] req_addr;
  logic          busy, ack, ack_ok;
  logic [AW-1:0] ack_addr;

  always #2.5 clk = ~clk;

  buddy_alloc #(.MIN_ORDER(MIN_ORDER), .LEVELS(LEVELS), .TOP_CNT(TOP_CNT)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_class(req_class), .req_addr(req_addr), .busy(busy), .ack(ack),
    .ack_ok(ack_ok), .ack_addr(ack_addr)
  );

  int n_chk = 0, n_fail = 0;
  bit occ [NG];
  int live_a [64];
  int live_c [64];
  int n_live = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit blk_free(input int l, input int i);
    for (int g = i << l; g < ((i + 1) << l); g++) if (occ[g]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit is_hole(input int l, input int i);
    return blk_free(l, i) && (l == TOP || !blk_free(l + 1, i >> 1));
  endfunction

  task automatic model_alloc(input int d, output bit ok, output int addr, output int lat);
    ok = 0; addr = 0; lat = 0;
    for (int x = d; x <= TOP && !ok; x++) begin
      for (int i = 0; i < (NG >> x) && !ok; i++) begin
        if (is_hole(x, i)) begin
          ok = 1; addr = (i << x) << MIN_ORDER; lat = x - d;
          for (int g = i << x; g < (i << x) + (1 << d); g++) occ[g] = 1'b1;
        end
      end
    end
  endtask

  task automatic model_free(input int d, input int addr, output int maddr, output int lat);
    int i, l;
    i = (addr >> MIN_ORDER) >> d;
    for (int g = i << d; g < (i + 1) << d; g++) occ[g] = 1'b0;
    l = d;
    while (l < TOP && blk_free(l + 1, i >> 1)) begin
      l++; i = i >> 1;
    end
    maddr = (i << l) << MIN_ORDER;
    lat = l - d + 1;
  endtask

  task automatic issue(input bit op, input int cls, input int addr, input bit poke,
                       output bit ok, output int ra, output int lat);
    @(negedge clk);
    check("R8 ack pulse ends", int'(ack), 0);
    req_valid = 1'b1; req_op = op; req_class = LW'(cls); req_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!ack && lat < 40) begin
      check("R7 busy while working", int'(busy), 1);
      if (poke && lat == 0) begin
        req_valid = 1'b1; req_op = 1'b0; req_class = LW'(TOP);
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end
    check("R8 busy low at ack", int'(busy), 0);
    ok = ack_ok; ra = int'(ack_addr);
  endtask

  task automatic do_alloc(input int d, input bit poke, output bit ok);
    bit eok, aok; int ea, elat, ra, lat;
    model_alloc(d, eok, ea, elat);
    issue(1'b0, d, 0, poke, aok, ra, lat);
    check(eok ? "R3 alloc ok" : "R4 alloc fail flag", int'(aok), int'(eok));
    check(eok ? "R2 alloc address" : "R4 fail address zero", ra, ea);
    check("R6 alloc latency", lat, elat);
    ok = eok;
    if (eok && aok) begin
      live_a[n_live] = ea; live_c[n_live] = d; n_live++;
    end
  endtask

  task automatic do_free(input int k);
    bit aok; int ma, elat, ra, lat, a, c;
    a = live_a[k]; c = live_c[k];
    n_live--;
    live_a[k] = live_a[n_live]; live_c[k] = live_c[n_live];
    model_free(c, a, ma, elat);
    issue(1'b1, c, a, 1'b0, aok, ra, lat);
    check("R5 release ok", int'(aok), 1);
    check("R5 merged address", ra, ma);
    check("R6 release latency", lat, elat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    rst = 1'b1; req_valid = 1'b0; req_op = 1'b0; req_class = '0; req_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 ack after reset", int'(ack), 0);

    // R7: stray request during a split must be ignored
    do_alloc(0, 1'b1, ok);
    do_alloc(TOP, 1'b0, ok);
    do_alloc(TOP, 1'b0, ok);
    while (n_live > 0) do_free(n_live - 1);

    // R3 R4 R5: fill at every class, release in varied orders
    for (int d = 0; d <= TOP; d++) begin
      ok = 1'b1;
      while (ok) do_alloc(d, 1'b0, ok);
      while (n_live > 0) do_free((d % 2 == 0) ? 0 : n_live - 1);
    end

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n_live == 0 || (lfsr[0] && n_live < 60)) do_alloc(int'(lfsr[3:1]) % LEVELS, 1'b0, ok);
      else do_free(int'(lfsr[11:4]) % n_live);
    end
    while (n_live > 0) do_free(int'(lfsr[7:0]) % n_live);

    // R1 R5: everything merged back to the top class
    do_alloc(TOP, 1'b0, ok);
    do_alloc(TOP, 1'b0, ok);
    do_alloc(0, 1'b0, ok);
    while (n_live > 0) do_free(0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule